// File: doc/BRIEF.md
# Modem Handshake and Auto-Enable Controller

This block sits beside one channel of a serial controller and handles its modem handshake lines. Two active-low status inputs come from the line side: clear-to-send and carrier-detect. Each passes through a synchronizer. The synchronized level can be read, and every change of level latches a sticky event flag that raises an interrupt request. When the auto-enable control bit is set, clear-to-send gates the transmitter and carrier-detect gates the receiver. When the bit is clear, both inputs are plain status lines.

On the output side the block drives an active-low request-to-send pin and a second active-low pin that has two uses. That second pin either reflects the terminal-ready bit or acts as a transmit DMA request for an external DMA engine. In asynchronous mode with auto-enable on, releasing request-to-send is held off until the transmitter has fully drained. In every other combination the pin follows its control bit. All control bits arrive as plain inputs from a register file outside this block. The transmitter reports its state through a drained flag and a buffer-empty flag.

Top module: `mdm_handshake`

## Requirements
- R1: `cts_lvl` and `dcd_lvl` show the pin levels of `cts_n_i` and `dcd_n_i` two clock edges after the pin changes. Both reset to 1, which means deasserted.
- R2: With `auto_en_bit`=1, `tx_enable` is 1 only while `tx_en_bit`=1 and the synchronized clear-to-send level is 0. It updates one edge after `cts_lvl`.
- R3: With `auto_en_bit`=0, `tx_enable` equals `tx_en_bit` one edge later, whatever the clear-to-send level.
- R4: `rx_enable` follows the same rules as R2 and R3, using `rx_en_bit` and the carrier-detect level.
- R5: Any change of `cts_lvl` or `dcd_lvl`, in either direction, sets `cts_evt` or `dcd_evt` one edge later. `ext_irq` is the OR of the two flags.
- R6: A one-cycle pulse on `clr_ext_stat` clears both event flags at the next edge. A level change detected at that same edge sets its flag regardless of the clear.
- R7: `rts_bit`=1 drives `rts_n_o` low at the next edge.
- R8: In asynchronous mode (`async_bit`=1) with `auto_en_bit`=1, clearing `rts_bit` keeps `rts_n_o` low until `tx_all_sent`=1. The pin then goes high at the next edge.
- R9: With `async_bit`=0, or with `auto_en_bit`=0, `rts_n_o` equals the inverse of `rts_bit` one edge later.
- R10: With `dtr_req_sel`=0, `dtr_req_n_o` equals the inverse of `dtr_bit` one edge later.
- R11: With `dtr_req_sel`=1, `dtr_req_n_o` is 0 exactly while `tx_buf_empty`=1 and the transmitter is qualified as in R2 and R3. It updates one edge after its inputs, and `dtr_bit` is ignored.
- R12: While `rst` is high, all outputs reach their idle values at the next edge: both enables 0, both pins 1, both levels 1, and all event flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| tx_en_bit | input | 1 | Transmitter enable control bit |
| rx_en_bit | input | 1 | Receiver enable control bit |
| auto_en_bit | input | 1 | Auto-enable mode bit |
| async_bit | input | 1 | 1 = asynchronous mode, 0 = synchronous |
| rts_bit | input | 1 | Request-to-send control bit |
| dtr_bit | input | 1 | Terminal-ready control bit |
| dtr_req_sel | input | 1 | 1 = second pin acts as transmit DMA request |
| tx_all_sent | input | 1 | Transmitter fully drained |
| tx_buf_empty | input | 1 | Transmit buffer empty |
| clr_ext_stat | input | 1 | Clear both event flags |
| tx_enable | output | 1 | Qualified transmitter enable |
| rx_enable | output | 1 | Qualified receiver enable |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| dtr_req_n_o | output | 1 | Terminal-ready or DMA request pin, active low |
| cts_lvl | output | 1 | Synchronized clear-to-send pin level |
| dcd_lvl | output | 1 | Synchronized carrier-detect pin level |
| cts_evt | output | 1 | Sticky clear-to-send change flag |
| dcd_evt | output | 1 | Sticky carrier-detect change flag |
| ext_irq | output | 1 | Interrupt request from either event flag |

## Verification
The bench drives a clear pulse in exactly the cycle that a new clear-to-send edge reaches the flag. A design that gives the clear priority would lose that edge and report no event. It clears request-to-send while the transmitter is still busy in asynchronous auto-enable mode, and holds that state for several cycles. A design that ignores the drain hold would raise the pin early, and one that never releases would keep it low after the drained flag arrives. It also checks that a rising edge on clear-to-send sets the event flag just as a falling edge does. It deasserts clear-to-send while the DMA request mode is active, so a request not gated by auto-enable would stay low.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned STAT_CNT = 2;
  localparam int unsigned IDX_CTS  = 0;
  localparam int unsigned IDX_DCD  = 1;

  typedef struct packed {
    logic auto_en;
    logic async_mode;
    logic rts;
    logic dtr;
    logic req_sel;
  } mdm_cfg_t;
endpackage

// File: rtl/mdm_stat_sync.sv
module mdm_stat_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic clr,
  output logic lvl,
  output logic evt
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], pin_n};
  end

  assign lvl = chain_q[TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      evt    <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (lvl != prev_q) evt <= 1'b1;
      else if (clr)      evt <= 1'b0;
    end
  end

  assert_edge_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |=> evt);
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && lvl == $past(lvl)) |=> !evt);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (evt && !clr) |=> evt);
endmodule

// File: rtl/mdm_rts_ctl.sv
module mdm_rts_ctl (
  input  logic clk,
  input  logic rst,
  input  logic rts_bit,
  input  logic hold_mode,
  input  logic tx_all_sent,
  output logic rts_n
);
  always_ff @(posedge clk) begin
    if (rst)                          rts_n <= 1'b1;
    else if (rts_bit)                 rts_n <= 1'b0;
    else if (hold_mode && !tx_all_sent) rts_n <= rts_n;
    else                              rts_n <= 1'b1;
  end

  assert_rts_set_R7: assert property (@(posedge clk) disable iff (rst)
    rts_bit |=> !rts_n);
  assert_rts_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && !rts_bit && !tx_all_sent && !rts_n) |=> !rts_n);
  assert_rts_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !hold_mode |=> (rts_n == !$past(rts_bit)));
endmodule

// File: rtl/mdm_dtr_sel.sv
module mdm_dtr_sel (
  input  logic clk,
  input  logic rst,
  input  logic req_sel,
  input  logic dtr_bit,
  input  logic req_active,
  output logic pin_n
);
  always_ff @(posedge clk) begin
    if (rst)          pin_n <= 1'b1;
    else if (req_sel) pin_n <= !req_active;
    else              pin_n <= !dtr_bit;
  end

  assert_dtr_mode_R10: assert property (@(posedge clk) disable iff (rst)
    !req_sel |=> (pin_n == !$past(dtr_bit)));
  assert_req_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (req_sel && !req_active) |=> pin_n);
endmodule

// File: rtl/mdm_handshake.sv
module mdm_handshake
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n_i,
  input  logic dcd_n_i,
  input  logic tx_en_bit,
  input  logic rx_en_bit,
  input  logic auto_en_bit,
  input  logic async_bit,
  input  logic rts_bit,
  input  logic dtr_bit,
  input  logic dtr_req_sel,
  input  logic tx_all_sent,
  input  logic tx_buf_empty,
  input  logic clr_ext_stat,
  output logic tx_enable,
  output logic rx_enable,
  output logic rts_n_o,
  output logic dtr_req_n_o,
  output logic cts_lvl,
  output logic dcd_lvl,
  output logic cts_evt,
  output logic dcd_evt,
  output logic ext_irq
);
  mdm_cfg_t            cfg;
  logic [STAT_CNT-1:0] pins_n;
  logic [STAT_CNT-1:0] lvl_v;
  logic [STAT_CNT-1:0] evt_v;
  logic                tx_go;
  logic                rx_go;

  assign cfg = '{auto_en: auto_en_bit, async_mode: async_bit, rts: rts_bit,
                 dtr: dtr_bit, req_sel: dtr_req_sel};

  assign pins_n[IDX_CTS] = cts_n_i;
  assign pins_n[IDX_DCD] = dcd_n_i;

  for (genvar g = 0; g < STAT_CNT; g++) begin : g_stat
    mdm_stat_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin_n(pins_n[g]),
      .clr  (clr_ext_stat),
      .lvl  (lvl_v[g]),
      .evt  (evt_v[g])
    );
  end

  assign tx_go = tx_en_bit && (!cfg.auto_en || !lvl_v[IDX_CTS]);
  assign rx_go = rx_en_bit && (!cfg.auto_en || !lvl_v[IDX_DCD]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_enable <= 1'b0;
      rx_enable <= 1'b0;
    end else begin
      tx_enable <= tx_go;
      rx_enable <= rx_go;
    end
  end

  mdm_rts_ctl u_rts (
    .clk        (clk),
    .rst        (rst),
    .rts_bit    (cfg.rts),
    .hold_mode  (cfg.async_mode && cfg.auto_en),
    .tx_all_sent(tx_all_sent),
    .rts_n      (rts_n_o)
  );

  mdm_dtr_sel u_dtr (
    .clk       (clk),
    .rst       (rst),
    .req_sel   (cfg.req_sel),
    .dtr_bit   (cfg.dtr),
    .req_active(tx_buf_empty && tx_go),
    .pin_n     (dtr_req_n_o)
  );

  assign cts_lvl = lvl_v[IDX_CTS];
  assign dcd_lvl = lvl_v[IDX_DCD];
  assign cts_evt = evt_v[IDX_CTS];
  assign dcd_evt = evt_v[IDX_DCD];
  assign ext_irq = |evt_v;

  assert_tx_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (auto_en_bit && cts_lvl) |=> !tx_enable);
  assert_tx_free_R3: assert property (@(posedge clk) disable iff (rst)
    !auto_en_bit |=> (tx_enable == $past(tx_en_bit)));
  assert_rx_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (auto_en_bit && dcd_lvl) |=> !rx_enable);
  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (!tx_enable && !rx_enable && rts_n_o && dtr_req_n_o && !ext_irq));
endmodule

// File: tb/sim_mdm_handshake.sv
module sim_mdm_handshake;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n_i = 1'b1, dcd_n_i = 1'b1;
  logic tx_en_bit = 0, rx_en_bit = 0, auto_en_bit = 0, async_bit = 0;
  logic rts_bit = 0, dtr_bit = 0, dtr_req_sel = 0;
  logic tx_all_sent = 0, tx_buf_empty = 0, clr_ext_stat = 0;
  logic tx_enable, rx_enable, rts_n_o, dtr_req_n_o;
  logic cts_lvl, dcd_lvl, cts_evt, dcd_evt, ext_irq;

  always #10 clk = ~clk;

  mdm_handshake u0 (.*);

  localparam int S_TXE = 0, S_RXE = 1, S_RTS = 2, S_DTR = 3, S_CTSL = 4,
                 S_DCDL = 5, S_CTSE = 6, S_DCDE = 7, S_IRQ = 8;

  typedef struct { int due; int sig; logic val; string req; } exp_t;
  exp_t sbq[$];
  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  function automatic logic sample(int sig);
    case (sig)
      S_TXE:   return tx_enable;
      S_RXE:   return rx_enable;
      S_RTS:   return rts_n_o;
      S_DTR:   return dtr_req_n_o;
      S_CTSL:  return cts_lvl;
      S_DCDL:  return dcd_lvl;
      S_CTSE:  return cts_evt;
      S_DCDE:  return dcd_evt;
      default: return ext_irq;
    endcase
  endfunction

  function automatic void push(int lat, int sig, logic val, string req);
    exp_t e;
    int pos;
    e.due = cyc + lat; e.sig = sig; e.val = val; e.req = req;
    pos = sbq.size();
    for (int i = 0; i < sbq.size(); i++)
      if (sbq[i].due > e.due) begin pos = i; break; end
    sbq.insert(pos, e);
  endfunction

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      logic act;
      e = sbq.pop_front();
      act = sample(e.sig);
      checks++;
      if (act !== e.val) begin
        failures++;
        $display("FAIL %s sig=%0d cycle=%0d actual=%0b expected=%0b",
                 e.req, e.sig, cyc, act, e.val);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R12: idle state after reset
    rst = 0;
    push(1, S_TXE, 0, "R12"); push(1, S_RXE, 0, "R12"); push(1, S_RTS, 1, "R12");
    push(1, S_DTR, 1, "R12"); push(1, S_CTSL, 1, "R12"); push(1, S_DCDL, 1, "R12");
    push(1, S_IRQ, 0, "R12");
    tick(2);
    // R3, R4: auto-enable off, status inputs do not gate
    tx_en_bit = 1; rx_en_bit = 1;
    push(1, S_TXE, 1, "R3"); push(1, S_RXE, 1, "R4");
    tick();
    cts_n_i = 0;
    push(2, S_CTSL, 0, "R1"); push(3, S_CTSE, 1, "R5"); push(3, S_IRQ, 1, "R5");
    push(3, S_TXE, 1, "R3");
    tick(4);
    clr_ext_stat = 1;
    push(1, S_CTSE, 0, "R6"); push(1, S_IRQ, 0, "R6");
    tick(); clr_ext_stat = 0; tick();
    // R2, R4: auto-enable on
    auto_en_bit = 1;
    push(1, S_TXE, 1, "R2"); push(1, S_RXE, 0, "R4");
    tick();
    cts_n_i = 1;
    push(2, S_CTSL, 1, "R1"); push(3, S_TXE, 0, "R2"); push(3, S_CTSE, 1, "R5");
    tick(4);
    dcd_n_i = 0;
    push(2, S_DCDL, 0, "R1"); push(3, S_RXE, 1, "R4"); push(3, S_DCDE, 1, "R5");
    tick(4);
    // R6: clear in the same edge as a new event, set wins
    cts_n_i = 0;
    push(3, S_CTSE, 1, "R6"); push(3, S_DCDE, 0, "R6"); push(3, S_TXE, 1, "R2");
    tick(2); clr_ext_stat = 1; tick(); clr_ext_stat = 0; tick(2);
    clr_ext_stat = 1;
    push(1, S_CTSE, 0, "R6"); push(1, S_DCDE, 0, "R6"); push(1, S_IRQ, 0, "R6");
    tick(); clr_ext_stat = 0; tick();
    // R7, R8: async with auto-enable, drain hold
    async_bit = 1; tx_all_sent = 0; rts_bit = 1;
    push(1, S_RTS, 0, "R7");
    tick();
    rts_bit = 0;
    push(1, S_RTS, 0, "R8"); push(4, S_RTS, 0, "R8");
    tick(4);
    tx_all_sent = 1;
    push(1, S_RTS, 1, "R8");
    tick();
    tx_all_sent = 0; rts_bit = 1;
    push(1, S_RTS, 0, "R7");
    tick();
    // R9: auto-enable off follows directly
    auto_en_bit = 0; rts_bit = 0;
    push(1, S_RTS, 1, "R9");
    tick();
    // R9: sync mode follows directly
    auto_en_bit = 1; async_bit = 0; rts_bit = 1;
    push(1, S_RTS, 0, "R7");
    tick();
    rts_bit = 0;
    push(1, S_RTS, 1, "R9");
    tick();
    // R10: terminal-ready mode
    dtr_bit = 1; push(1, S_DTR, 0, "R10"); tick();
    dtr_bit = 0; push(1, S_DTR, 1, "R10"); tick();
    // R11: DMA request mode, dtr_bit ignored
    dtr_req_sel = 1; dtr_bit = 1; tx_buf_empty = 0;
    push(1, S_DTR, 1, "R11"); tick();
    tx_buf_empty = 1; push(1, S_DTR, 0, "R11"); tick();
    tx_en_bit = 0;    push(1, S_DTR, 1, "R11"); tick();
    tx_en_bit = 1;    push(1, S_DTR, 0, "R11"); tick();
    cts_n_i = 1;      push(3, S_DTR, 1, "R11"); tick(4);
    auto_en_bit = 0;  push(1, S_DTR, 0, "R11"); tick();
    dtr_req_sel = 0;  push(1, S_DTR, 0, "R10"); tick();
    tick(4);
    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sbq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule